// File: doc/BRIEF.md
# Serial Word Transmitter with Double-Edge Clock Forwarding

This block sends a parallel word one bit at a time on a single data line and produces a matching clock for the receiver. The word is captured when a load strobe is seen while the block is idle and enabled. The most significant bit goes out first. Each bit is launched on a falling edge of the reference clock, so it is steady when the receiver samples on the next rising edge of the forwarded clock.

The forwarded clock is built by a pair of flops that change state on opposite edges of the reference clock. Their XOR drives the pin. The reference clock therefore never feeds a gate or a mux. While a transfer runs, the pin follows the reference clock. At all other times it stays at logic 1, which tells the receiver that no bits are coming. The switch between these two behaviours happens only on a clock edge, so the pin never shows a runt pulse.

A one-cycle completion pulse marks the end of each word. Dropping the enable input abandons a transfer at the next rising edge.

Top module: `ser_fwd`

## Requirements
- R1: While reset is asserted and right after it is released: sclk_out is 1, sdata is 0, busy is 0 and done is 0.
- R2: A rising edge that samples load=1, en=1 and busy=0 captures din, and busy reads 1 after that edge.
- R3: The captured word appears on sdata with bit 7 first and bit 0 last. Every change of sdata happens while the reference clock is low, so the value taken at each rising edge of sclk_out rebuilds the word exactly.
- R4: Each completed word produces exactly 8 rising edges on sclk_out. At every rising edge of the reference clock, the sclk_out value sampled just before that edge equals the inverse of busy.
- R5: While busy is 0, sclk_out stays at 1 through the whole clock period.
- R6: done is 1 for exactly one cycle, starting at the 8th rising edge after the loading edge. busy falls at that same edge.
- R7: A load strobe that arrives while busy is 1 has no effect: the word in flight and its length are unchanged.
- R8: With en=0, load is ignored. A transfer in progress ends at the next rising edge, busy falls and no done pulse is given.
- R9: While idle, sdata keeps the last bit it carried (or 0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable |
| load | input | 1 | Start strobe, sampled on the rising edge |
| din | input | W | Parallel word to send |
| sdata | output | 1 | Serial data, changes on falling edges |
| sclk_out | output | 1 | Forwarded clock, rests high when idle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a word |

## Verification
Two events can fall in the same cycle. A new load strobe can meet a word that is still being sent, and the enable can drop in the middle of a shift. The bench provokes the first by pulsing load, with an inverted word on din, in the middle of a transfer. It then judges the word rebuilt from the forwarded clock edges against the original word. It provokes the second by lowering en after a few bits. It then requires busy to fall at the next edge, no done pulse to appear, and the forwarded clock to park high with no further edges.

// File: rtl/ser_fwd.sv
module ser_fwd #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sdata,
  output logic         sclk_out,
  output logic         busy,
  output logic         done
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic          active;
  logic [IW-1:0] idx;
  logic [W-1:0]  sr;
  logic          done_q;
  logic          sd_q;
  logic          fwd_p, fwd_n;

  wire start  = en && load && !active;
  wire rise_d = 1'b1;
  wire fall_d = ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= IW'(W - 1);
      sr     <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        active <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        sr     <= din;
        idx    <= IW'(W - 1);
      end else if (active) begin
        if (idx == '0) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      sd_q <= 1'b0;
    else if (active) sd_q <= sr[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_p <= 1'b1;
    else        fwd_p <= rise_d ^ fwd_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fwd_n <= 1'b0;
    else        fwd_n <= fall_d ^ fwd_p;
  end

  assign sclk_out = fwd_p ^ fwd_n;
  assign sdata    = sd_q;
  assign busy     = active;
  assign done     = done_q;
endmodule

// File: rtl/ser_fwd_chk.sv
module ser_fwd_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic load,
  input logic sdata,
  input logic sclk_out,
  input logic busy,
  input logic done
);
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load && !busy) |=> busy);

  p_start_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && load));

  p_clk_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out == !busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(busy, 8)));

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !done));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(sdata));
endmodule

bind ser_fwd ser_fwd_chk chk (
  .clk(clk), .rst_n(rst_n), .en(en), .load(load), .sdata(sdata),
  .sclk_out(sclk_out), .busy(busy), .done(done)
);

// File: tb/ser_fwd_test.sv
`timescale 1ns/1ps
module ser_fwd_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [7:0] din = '0;
  logic       sdata, sclk_out, busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] rx;
  int         rx_n;
  bit         rx_arm = 1'b0;
  int         sd_viol = 0;

  always #2 clk = ~clk;

  ser_fwd uut (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .din(din),
    .sdata(sdata), .sclk_out(sclk_out), .busy(busy), .done(done)
  );

  always @(posedge sclk_out) if (rx_arm) begin
    rx   = {rx[6:0], sdata};
    rx_n = rx_n + 1;
  end

  always @(sdata) if (rx_arm && clk) sd_viol = sd_viol + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] expect_word(input bit [7:0] w);
    return w;
  endfunction

  task automatic send(input bit [7:0] w, input bit mid_load);
    int done_at = -1;
    bit clk_hi_ok = 1'b1;
    rx = '0; rx_n = 0; sd_viol = 0; rx_arm = 1'b1;
    @(negedge clk);
    din = w; load = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 0) begin
        load = 1'b0;
        chk(busy == 1'b1, "R2 busy after load", busy, 1);
      end
      if (mid_load && k == 3) begin load = 1'b1; din = ~w; end
      if (mid_load && k == 4) load = 1'b0;
      if (done) begin done_at = k; break; end
    end
    chk(done_at == 8, "R6 done timing", done_at, 8);
    chk(busy == 1'b0, "R6 busy falls with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    rx_arm = 1'b0;
    chk(rx == expect_word(w), mid_load ? "R7 word unchanged by load" : "R3 rebuilt word",
        rx, expect_word(w));
    chk(rx_n == 8, "R4 rising edge count", rx_n, 8);
    chk(sd_viol == 0, "R3 sdata changed while clk high", sd_viol, 0);
    for (int k = 0; k < 4; k++) begin
      #1; if (sclk_out !== 1'b1) clk_hi_ok = 1'b0;
      @(negedge clk);
      #1; if (sclk_out !== 1'b1) clk_hi_ok = 1'b0;
      @(posedge clk);
    end
    chk(clk_hi_ok, "R5 clock high while idle", clk_hi_ok, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit hold_ok, hi_ok, no_done;
    logic last_sd;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(sclk_out == 1'b1 && sdata == 1'b0, "R1 reset outputs", {sclk_out, sdata}, 2'b10);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset status", {busy, done}, 0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    chk(sclk_out == 1'b1 && busy == 1'b0, "R1 after release", {sclk_out, busy}, 2'b10);

    send(8'hA5, 1'b0);
    send(8'h00, 1'b0);
    send(8'hFF, 1'b0);
    send(8'h80, 1'b0);
    send(8'h01, 1'b0);
    send(8'h3C, 1'b1);

    last_sd = sdata;
    hold_ok = 1'b1;
    repeat (6) begin @(negedge clk); #1; if (sdata !== last_sd) hold_ok = 1'b0; end
    chk(hold_ok, "R9 sdata holds while idle", sdata, last_sd);

    en = 1'b0; rx_n = 0; rx_arm = 1'b1;
    din = 8'h5A; load = 1'b1;
    @(negedge clk); load = 1'b0;
    hi_ok = 1'b1;
    repeat (12) begin @(negedge clk); #1; if (sclk_out !== 1'b1 || busy) hi_ok = 1'b0; end
    rx_arm = 1'b0;
    chk(hi_ok && rx_n == 0, "R8 load ignored when disabled", rx_n, 0);
    en = 1'b1;

    @(negedge clk);
    din = 8'hC3; load = 1'b1;
    @(negedge clk); load = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8 abort clears busy", busy, 0);
    rx_n = 0; rx_arm = 1'b1; no_done = 1'b1; hi_ok = 1'b1;
    repeat (10) begin @(negedge clk); #1; if (done) no_done = 1'b0; if (sclk_out !== 1'b1) hi_ok = 1'b0; end
    rx_arm = 1'b0;
    chk(no_done, "R8 no done after abort", no_done, 1);
    chk(hi_ok && rx_n == 0, "R8 clock parked after abort", rx_n, 0);
    en = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 20; i++) send(8'($urandom), ($urandom % 4) == 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule